// File: doc/BRIEF.md
# Priority-Gated DMA Request Arbiter

This block decides, once per clock, whether one of several DMA channels may take the bus. A transfer is permitted only while the programmed DMA priority level is at least the CPU's current operating level. When the CPU raises its level above the DMA level, every grant is withheld, so critical code runs with no DMA activity. Among channels that request together, the lowest channel index is granted, and only one grant is active at a time.

The block also settles contention between DMA and a pending CPU interrupt. When both want service in the same cycle, the DMA transfer is chosen. The interrupt is accepted only in cycles where no DMA grant is issued.

When a channel finishes, it raises a per-channel done event. The block remembers these events and presents one interrupt request at a time. Each request carries the finishing channel's own vector index, so the handler needs no polling. All channels share one interrupt priority, taken from a configuration input. The lowest pending channel is presented first, and an acknowledge retires it. All outputs are registered, with one cycle of latency from the inputs.

Top module: `dma_prio_arbiter`

## Requirements
- R1: When `dma_lvl >= cpu_lvl` (unsigned 2-bit levels, 0 to 3) and any `dma_req` bit is set at a clock edge, `dma_gnt` is non-zero after that edge.
- R2: When `cpu_lvl > dma_lvl` at a clock edge, `dma_gnt` is all zeros after that edge, whatever `dma_req` holds.
- R3: `dma_gnt` has at most one bit set, and that bit is the lowest-index channel whose `dma_req` bit was set at the edge.
- R4: `irq_take` is set after an edge where `irq_pend` was high and no DMA grant was issued. If a grant was issued at that edge, `irq_take` stays low, and it is never high together with a grant.
- R5: A `ch_done[i]` pulse marks channel i pending. After that edge `ch_irq_valid` is high and `ch_irq_vec` holds i, provided no lower channel is pending.
- R6: While several channels are pending, `ch_irq_vec` shows the lowest pending index. When `irq_ack` is high while `ch_irq_valid` is high at an edge, the shown channel is cleared and the next lowest appears after that edge. `ch_irq_vec` is 0 when nothing is pending.
- R7: `ch_irq_lvl` equals the value `irq_lvl_cfg` had at the previous clock edge. This is the one interrupt priority shared by all channels.
- R8: If a channel's done pulse arrives in the same edge as the acknowledge of that same channel, the channel stays pending.
- R9: While `rst` is high at an edge, all outputs are zero after it and all pending marks are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | N_CH | Per-channel transfer request |
| dma_lvl | input | 2 | Programmed DMA priority level |
| cpu_lvl | input | 2 | Current CPU operating level |
| irq_pend | input | 1 | A CPU interrupt wants service |
| ch_done | input | N_CH | Per-channel completion pulse |
| irq_lvl_cfg | input | 2 | Shared priority for channel interrupts |
| irq_ack | input | 1 | Acknowledge of the presented channel interrupt |
| dma_gnt | output | N_CH | One-hot bus grant |
| irq_take | output | 1 | CPU interrupt accepted this cycle |
| ch_irq_valid | output | 1 | A channel interrupt is presented |
| ch_irq_vec | output | clog2(N_CH) | Vector index of the presented channel |
| ch_irq_lvl | output | 2 | Priority of the presented interrupt |

## Verification
The bench aims at the level comparison at equality and one step either side. A design with an off-by-one comparison would either drop grants when the two levels match or grant while the CPU sits one level higher. It drives interrupts together with requests that are allowed and requests that are gated. A design that let the interrupt win would assert `irq_take` beside a grant. A design that ignored the gate would refuse the interrupt while DMA is actually blocked. It also stacks done pulses on several channels, acknowledges them out of step, and lands a fresh done pulse on the channel being acknowledged. A wrong clear would lose that event or show a higher vector before a lower one.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/dma_first_one.sv
// Lowest-index selector: one-hot mask, encoded index and an any flag.
module dma_first_one #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign onehot[i]  = req[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req[i];
  end

  assign any = seen[W];

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma_level_gate.sv
// Permits DMA only while its programmed level is not below the CPU level.
module dma_level_gate
  import dma_arb_pkg::*;
(
  input  lvl_t dma_lvl,
  input  lvl_t cpu_lvl,
  output logic allow
);
  assign allow = (dma_lvl >= cpu_lvl);
endmodule

// File: rtl/dma_irq_tracker.sv
// Holds per-channel completion marks and presents the lowest one.
module dma_irq_tracker #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  done,
  input  logic          ack,
  output logic          vld,
  output logic [IW-1:0] vec
);
  logic [N-1:0]  pend_q;
  logic [N-1:0]  pend_nxt;
  logic [N-1:0]  clr_mask;
  logic [N-1:0]  pick_oh;
  logic [IW-1:0] pick_idx;
  logic          pick_any;

  always_comb begin
    clr_mask = '0;
    if (ack && vld) clr_mask[vec] = 1'b1;
    pend_nxt = (pend_q & ~clr_mask) | done;
  end

  dma_first_one #(.W(N), .IW(IW)) u_pick (
    .req    (pend_nxt),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      vld    <= 1'b0;
      vec    <= '0;
    end else begin
      pend_q <= pend_nxt;
      vld    <= pick_any;
      vec    <= pick_idx;
    end
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   dma_req,
  input  logic [1:0]        dma_lvl,
  input  logic [1:0]        cpu_lvl,
  input  logic              irq_pend,
  input  logic [N_CH-1:0]   ch_done,
  input  logic [1:0]        irq_lvl_cfg,
  input  logic              irq_ack,
  output logic [N_CH-1:0]   dma_gnt,
  output logic              irq_take,
  output logic              ch_irq_valid,
  output logic [IDX_W-1:0]  ch_irq_vec,
  output logic [1:0]        ch_irq_lvl
);
  logic              allow;
  logic [N_CH-1:0]   gated_req;
  logic [N_CH-1:0]   gnt_nxt;
  logic [IDX_W-1:0]  gnt_idx_unused;
  logic              gnt_any;

  dma_level_gate u_gate (
    .dma_lvl (lvl_t'(dma_lvl)),
    .cpu_lvl (lvl_t'(cpu_lvl)),
    .allow   (allow)
  );

  assign gated_req = allow ? dma_req : '0;

  dma_first_one #(.W(N_CH), .IW(IDX_W)) u_grant_pick (
    .req    (gated_req),
    .onehot (gnt_nxt),
    .idx    (gnt_idx_unused),
    .any    (gnt_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_gnt    <= '0;
      irq_take   <= 1'b0;
      ch_irq_lvl <= '0;
    end else begin
      dma_gnt    <= gnt_nxt;
      irq_take   <= irq_pend & ~gnt_any;
      ch_irq_lvl <= irq_lvl_cfg;
    end
  end

  dma_irq_tracker #(.N(N_CH), .IW(IDX_W)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .done (ch_done),
    .ack  (irq_ack),
    .vld  (ch_irq_valid),
    .vec  (ch_irq_vec)
  );
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int N_CH = 4,
  parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [N_CH-1:0]   dma_req,
  input logic [1:0]        dma_lvl,
  input logic [1:0]        cpu_lvl,
  input logic              irq_pend,
  input logic [N_CH-1:0]   ch_done,
  input logic [1:0]        irq_lvl_cfg,
  input logic              irq_ack,
  input logic [N_CH-1:0]   dma_gnt,
  input logic              irq_take,
  input logic              ch_irq_valid,
  input logic [IDX_W-1:0]  ch_irq_vec,
  input logic [1:0]        ch_irq_lvl
);
  a_r1_on_demand: assert property (@(posedge clk) disable iff (rst)
    (dma_lvl >= cpu_lvl && |dma_req) |=> |dma_gnt);

  a_r2_gated_off: assert property (@(posedge clk) disable iff (rst)
    (cpu_lvl > dma_lvl) |=> (dma_gnt == '0));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dma_gnt));

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    (|dma_req) |=> (((dma_gnt - 1'b1) & $past(dma_req) & {N_CH{|dma_gnt}}) == '0));

  a_r4_dma_first: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && |dma_req && dma_lvl >= cpu_lvl) |=> !irq_take);

  a_r4_never_both: assert property (@(posedge clk) disable iff (rst)
    !(irq_take && |dma_gnt));

  a_r5_done_presents: assert property (@(posedge clk) disable iff (rst)
    (|ch_done) |=> ch_irq_valid);

  a_r6_ack_retires: assert property (@(posedge clk) disable iff (rst)
    (ch_irq_valid && irq_ack && ch_done == '0) |=>
      !(ch_irq_valid && ch_irq_vec == $past(ch_irq_vec)));

  a_r7_shared_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ch_irq_lvl == $past(irq_lvl_cfg)));

  a_r8_done_beats_ack: assert property (@(posedge clk) disable iff (rst)
    (ch_irq_valid && irq_ack && ch_done[ch_irq_vec]) |=> ch_irq_valid);
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;
  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  dma_req;
  logic [1:0]    dma_lvl, cpu_lvl, irq_lvl_cfg;
  logic          irq_pend, irq_ack;
  logic [N-1:0]  ch_done;
  logic [N-1:0]  dma_gnt;
  logic          irq_take, ch_irq_valid;
  logic [IW-1:0] ch_irq_vec;
  logic [1:0]    ch_irq_lvl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  bit pend [N];
  int e_gnt, e_take, e_vld, e_vec, e_lvl;
  string t_gnt, t_take, t_irq;

  always #2 clk = ~clk;

  dma_prio_arbiter #(.N_CH(N)) i_dma_prio_arbiter (
    .clk, .rst, .dma_req, .dma_lvl, .cpu_lvl, .irq_pend, .ch_done,
    .irq_lvl_cfg, .irq_ack, .dma_gnt, .irq_take, .ch_irq_valid,
    .ch_irq_vec, .ch_irq_lvl
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  task automatic check_all();
    chk(t_gnt,  "dma_gnt",      int'(dma_gnt),      e_gnt);
    chk(t_take, "irq_take",     int'(irq_take),     e_take);
    chk(t_irq,  "ch_irq_valid", int'(ch_irq_valid), e_vld);
    chk(t_irq,  "ch_irq_vec",   int'(ch_irq_vec),   e_vec);
    chk(rst ? "R9" : "R7", "ch_irq_lvl", int'(ch_irq_lvl), e_lvl);
  endtask

  // Compute expectations for the edge that follows, from current inputs.
  task automatic predict();
    int lo;
    int hit_ack;
    if (rst) begin
      e_gnt = 0; e_take = 0; e_vld = 0; e_vec = 0; e_lvl = 0;
      for (int i = 0; i < N; i++) pend[i] = 0;
      t_gnt = "R9"; t_take = "R9"; t_irq = "R9";
      return;
    end
    lo = -1;
    if (dma_lvl >= cpu_lvl)
      for (int i = N - 1; i >= 0; i--) if (dma_req[i]) lo = i;
    e_gnt = (lo < 0) ? 0 : (1 << lo);
    if (cpu_lvl > dma_lvl) t_gnt = "R2";
    else if ($countones(dma_req) > 1) t_gnt = "R3";
    else t_gnt = "R1";
    e_take = (irq_pend && lo < 0) ? 1 : 0;
    t_take = "R4";
    hit_ack = -1;
    if (irq_ack && e_vld) begin
      hit_ack = e_vec;
      pend[e_vec] = 0;
    end
    t_irq = (irq_ack && e_vld) ? "R6" : "R5";
    for (int i = 0; i < N; i++) if (ch_done[i]) begin
      pend[i] = 1;
      if (i == hit_ack) t_irq = "R8";
    end
    e_vld = 0; e_vec = 0;
    for (int i = N - 1; i >= 0; i--) if (pend[i]) begin e_vld = 1; e_vec = i; end
    e_lvl = int'(irq_lvl_cfg);
  endtask

  task automatic step(logic [N-1:0] rq, logic [1:0] dl, logic [1:0] cl,
                      logic ip, logic [N-1:0] dn, logic [1:0] il, logic ak);
    check_all();
    dma_req = rq; dma_lvl = dl; cpu_lvl = cl; irq_pend = ip;
    ch_done = dn; irq_lvl_cfg = il; irq_ack = ak;
    predict();
    @(negedge clk);
    cycles++;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    dma_req = '1; dma_lvl = 2'd3; cpu_lvl = 2'd0; irq_pend = 1'b1;
    ch_done = '1; irq_lvl_cfg = 2'd2; irq_ack = 1'b0;
    predict();
    @(negedge clk);
    @(negedge clk);
    // R9: reset state with busy inputs
    check_all();
    rst = 1'b0;
    dma_req = '0; ch_done = '0; irq_pend = 1'b0;
    predict();
    @(negedge clk);

    // R1: equal levels grant
    step(4'b0100, 2'd1, 2'd1, 1'b0, 4'b0000, 2'd1, 1'b0);
    // R2: CPU one above DMA blocks
    step(4'b0100, 2'd1, 2'd2, 1'b0, 4'b0000, 2'd1, 1'b0);
    // R1: DMA above CPU
    step(4'b1000, 2'd3, 2'd0, 1'b0, 4'b0000, 2'd1, 1'b0);
    // R3: lowest index wins
    step(4'b1110, 2'd2, 2'd2, 1'b0, 4'b0000, 2'd3, 1'b0);
    step(4'b1111, 2'd2, 2'd2, 1'b0, 4'b0000, 2'd3, 1'b0);
    // R4: tie, DMA first
    step(4'b0010, 2'd2, 2'd1, 1'b1, 4'b0000, 2'd3, 1'b0);
    // R4: gated DMA lets interrupt in
    step(4'b0010, 2'd0, 2'd3, 1'b1, 4'b0000, 2'd3, 1'b0);
    // R4: no requests
    step(4'b0000, 2'd3, 2'd0, 1'b1, 4'b0000, 2'd0, 1'b0);
    // R5/R6: stack done events on 3 and 1, then 2
    step(4'b0000, 2'd3, 2'd0, 1'b0, 4'b1010, 2'd1, 1'b0);
    step(4'b0000, 2'd3, 2'd0, 1'b0, 4'b0100, 2'd1, 1'b0);
    step(4'b0000, 2'd3, 2'd0, 1'b0, 4'b0000, 2'd1, 1'b1);
    // R8: done on the channel being acknowledged (2)
    step(4'b0000, 2'd3, 2'd0, 1'b0, 4'b0100, 2'd1, 1'b1);
    step(4'b0000, 2'd3, 2'd0, 1'b0, 4'b0000, 2'd1, 1'b1);
    step(4'b0000, 2'd3, 2'd0, 1'b0, 4'b0000, 2'd1, 1'b1);
    step(4'b0000, 2'd3, 2'd0, 1'b0, 4'b0000, 2'd1, 1'b1);
    // R6: ack with nothing pending has no effect
    step(4'b0000, 2'd3, 2'd0, 1'b0, 4'b0000, 2'd1, 1'b1);

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] rq, dn;
      rq = N'($urandom);
      dn = (($urandom % 4) == 0) ? N'($urandom) : '0;
      step(rq, 2'($urandom), 2'($urandom), 1'($urandom), dn,
           2'($urandom), (($urandom % 3) != 0));
    end

    // R9: reset mid-run clears pending marks
    step('0, 2'd3, 2'd0, 1'b0, 4'b1111, 2'd2, 1'b0);
    rst = 1'b1;
    step('1, 2'd3, 2'd0, 1'b1, 4'b0000, 2'd2, 1'b0);
    step('1, 2'd3, 2'd0, 1'b1, 4'b0000, 2'd2, 1'b0);
    rst = 1'b0;
    step('0, 2'd3, 2'd0, 1'b0, 4'b0000, 2'd2, 1'b0);
    step('0, 2'd3, 2'd0, 1'b0, 4'b0000, 2'd2, 1'b0);
    check_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule